// File: doc/BRIEF.md
# Three-Register Exchange Controller

This block swaps the contents of two working registers, A and B, over one shared bus. A third register, T, holds one of the values while the swap is in progress. A Mealy controller produces the capture enables and bus-drive selects for the three registers. Because its first set of controls depends directly on the start input while the controller is idle, a swap takes three clock cycles from the cycle in which the request is seen.

A small datapath is built in so the controller can be exercised as a unit. It contains three W-bit registers and a bus multiplexer built from AND-OR gates, which stands in for tri-state drivers. Preset ports write A and B directly. The drive and capture controls are brought out as ports, along with the three register values, so a surrounding design or a bench can watch every step.

Top module: `xchg_unit`

## Requirements
- R1: When rst_n is low, the controller is forced at once, with no clock edge needed, into its idle state (two state bits, both 0). In that state, with start low, all seven control outputs are 0. Reset also clears a_val, b_val and t_val to 0.
- R2: While idle with start low, the controller stays idle and every control output is 0.
- R3: While idle with start high, drv_b and cap_t are 1 in that same cycle, with no clock edge needed, and the controller moves to its first busy state at the next rising edge.
- R4: In the first busy state, drv_a and cap_b are 1. In the second busy state, drv_t, cap_a and done are 1. The controller then returns to idle. A full swap therefore spans three cycles.
- R5: At most one of drv_a, drv_b and drv_t is 1 in any cycle. When none of them is 1, no capture enable is 1 and no register changes.
- R6: done is 1 for exactly one cycle per swap, and never in two consecutive cycles.
- R7: At a rising edge, a register whose capture enable is 1 loads the bus value. After a completed swap, a_val and b_val hold each other's earlier values, and t_val holds the earlier b_val.
- R8: A high start in either busy state has no effect. Only a start sampled high while idle begins a swap.
- R9: A high load_a or load_b writes a_pre or b_pre into A or B at the next rising edge. If a bus capture into the same register falls in that cycle, the preset value wins.
- R10: A start that is high in the cycle right after the done cycle begins a new swap with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Swap request, sampled while idle |
| load_a | input | 1 | Preset strobe for register A |
| a_pre | input | W | Preset value for register A |
| load_b | input | 1 | Preset strobe for register B |
| b_pre | input | W | Preset value for register B |
| drv_a | output | 1 | Register A drives the bus |
| drv_b | output | 1 | Register B drives the bus |
| drv_t | output | 1 | Register T drives the bus |
| cap_a | output | 1 | Register A captures the bus |
| cap_b | output | 1 | Register B captures the bus |
| cap_t | output | 1 | Register T captures the bus |
| done | output | 1 | One-cycle pulse in the last swap cycle |
| a_val | output | W | Current content of A |
| b_val | output | W | Current content of B |
| t_val | output | W | Current content of T |

## Verification
A preset write into A can land in the same cycle as the last swap step, when cap_a is loading A from the bus. The bench raises load_a with a distinct pattern in exactly the cycle where done is high. It then judges the result one edge later: a_val must equal the preset pattern rather than the saved value. B and T must still show their completed swap values. A second collision, a reset arriving in the first busy state, is judged by all controls dropping at once and the next request running a clean three-cycle swap.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_MOVE  = 2'b01,
        ST_PARK  = 2'b10
    } xchg_state_e;

    localparam int unsigned NREG  = 3;
    localparam int unsigned IDX_A = 0;
    localparam int unsigned IDX_B = 1;
    localparam int unsigned IDX_T = 2;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
        logic drv_t;
        logic cap_a;
        logic cap_b;
        logic cap_t;
        logic done;
    } xchg_ctl_t;

endpackage

// File: rtl/xchg_fsm.sv
module xchg_fsm
    import xchg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output xchg_ctl_t ctl
);

    typedef struct packed {
        xchg_state_e st;
    } fsm_reg_t;

    fsm_reg_t  r_d, r_q;
    xchg_ctl_t ctl_d;

    always_comb begin
        r_d   = r_q;
        ctl_d = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.drv_b = 1'b1;
                    ctl_d.cap_t = 1'b1;
                    r_d.st      = ST_MOVE;
                end
            end
            ST_MOVE: begin
                ctl_d.drv_a = 1'b1;
                ctl_d.cap_b = 1'b1;
                r_d.st      = ST_PARK;
            end
            ST_PARK: begin
                ctl_d.drv_t = 1'b1;
                ctl_d.cap_a = 1'b1;
                ctl_d.done  = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/xchg_bus.sv
module xchg_bus #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0]        drive,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = src[i] & {W{drive[i]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < int'(N); i++) begin
            bus = bus | gated[i];
        end
    end

endmodule

// File: rtl/xchg_regs.sv
module xchg_regs #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cap,
    input  logic [N-1:0]        pre_en,
    input  logic [N-1:0][W-1:0] pre_val,
    input  logic [W-1:0]        bus,
    output logic [N-1:0][W-1:0] val
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        logic [W-1:0] v_d, v_q;

        always_comb begin
            v_d = v_q;
            if (pre_en[i]) begin
                v_d = pre_val[i];
            end else if (cap[i]) begin
                v_d = bus;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= '0;
            end else begin
                v_q <= v_d;
            end
        end

        assign val[i] = v_q;
    end

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
    import xchg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         load_a,
    input  logic [W-1:0] a_pre,
    input  logic         load_b,
    input  logic [W-1:0] b_pre,
    output logic         drv_a,
    output logic         drv_b,
    output logic         drv_t,
    output logic         cap_a,
    output logic         cap_b,
    output logic         cap_t,
    output logic         done,
    output logic [W-1:0] a_val,
    output logic [W-1:0] b_val,
    output logic [W-1:0] t_val
);

    xchg_ctl_t              ctl;
    logic [NREG-1:0]        drive_v;
    logic [NREG-1:0]        cap_v;
    logic [NREG-1:0]        pre_en_v;
    logic [NREG-1:0][W-1:0] pre_val_v;
    logic [NREG-1:0][W-1:0] reg_v;
    logic [W-1:0]           bus;

    xchg_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl)
    );

    always_comb begin
        drive_v          = '0;
        cap_v            = '0;
        pre_en_v         = '0;
        pre_val_v        = '0;
        drive_v[IDX_A]   = ctl.drv_a;
        drive_v[IDX_B]   = ctl.drv_b;
        drive_v[IDX_T]   = ctl.drv_t;
        cap_v[IDX_A]     = ctl.cap_a;
        cap_v[IDX_B]     = ctl.cap_b;
        cap_v[IDX_T]     = ctl.cap_t;
        pre_en_v[IDX_A]  = load_a;
        pre_en_v[IDX_B]  = load_b;
        pre_val_v[IDX_A] = a_pre;
        pre_val_v[IDX_B] = b_pre;
    end

    xchg_bus #(.W(W), .N(NREG)) u_bus (
        .drive (drive_v),
        .src   (reg_v),
        .bus   (bus)
    );

    xchg_regs #(.W(W), .N(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap_v),
        .pre_en  (pre_en_v),
        .pre_val (pre_val_v),
        .bus     (bus),
        .val     (reg_v)
    );

    assign drv_a = ctl.drv_a;
    assign drv_b = ctl.drv_b;
    assign drv_t = ctl.drv_t;
    assign cap_a = ctl.cap_a;
    assign cap_b = ctl.cap_b;
    assign cap_t = ctl.cap_t;
    assign done  = ctl.done;
    assign a_val = reg_v[IDX_A];
    assign b_val = reg_v[IDX_B];
    assign t_val = reg_v[IDX_T];

endmodule

// File: rtl/xchg_unit_chk.sv
module xchg_unit_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_a,
    input logic         load_b,
    input logic         drv_a,
    input logic         drv_b,
    input logic         drv_t,
    input logic         cap_a,
    input logic         cap_b,
    input logic         cap_t,
    input logic         done,
    input logic [W-1:0] a_val,
    input logic [W-1:0] b_val,
    input logic [W-1:0] t_val
);

    p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_a, drv_b, drv_t}));

    p_no_cap_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a || drv_b || drv_t) |-> !(cap_a || cap_b || cap_t));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_step_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_b && cap_t) |=> (drv_a && cap_b && !done));

    p_step_three_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a && cap_b) |=> (drv_t && cap_a && done));

    p_save_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_b && cap_t) |=> (t_val == $past(b_val)));

    p_restore_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_t && cap_a && !load_a) |=> (a_val == $past(t_val)));

    p_move_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a && cap_b && !load_b) |=> (b_val == $past(a_val)));

endmodule

bind xchg_unit xchg_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_a (load_a),
    .load_b (load_b),
    .drv_a  (drv_a),
    .drv_b  (drv_b),
    .drv_t  (drv_t),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .cap_t  (cap_t),
    .done   (done),
    .a_val  (a_val),
    .b_val  (b_val),
    .t_val  (t_val)
);

// File: tb/xchg_unit_tb_top.sv
module xchg_unit_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         load_a = 1'b0;
    logic         load_b = 1'b0;
    logic [W-1:0] a_pre = '0;
    logic [W-1:0] b_pre = '0;
    logic         drv_a, drv_b, drv_t, cap_a, cap_b, cap_t, done;
    logic [W-1:0] a_val, b_val, t_val;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    xchg_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_a(load_a), .a_pre(a_pre), .load_b(load_b), .b_pre(b_pre),
        .drv_a(drv_a), .drv_b(drv_b), .drv_t(drv_t),
        .cap_a(cap_a), .cap_b(cap_b), .cap_t(cap_t), .done(done),
        .a_val(a_val), .b_val(b_val), .t_val(t_val)
    );

    // control order {drv_a, drv_b, drv_t, cap_a, cap_b, cap_t, done}
    localparam logic [6:0] C_IDLE = 7'b0000000;
    localparam logic [6:0] C_GO   = 7'b0100010;
    localparam logic [6:0] C_MOVE = 7'b1000100;
    localparam logic [6:0] C_PARK = 7'b0011001;

    // row = {start, ctl[6:0], a[7:0], b[7:0], t[7:0]}
    localparam int NROW = 12;
    localparam logic [31:0] TBL [NROW] = '{
        {1'b0, C_IDLE, 8'h3C, 8'hA5, 8'h00},
        {1'b1, C_GO,   8'h3C, 8'hA5, 8'h00},
        {1'b1, C_MOVE, 8'h3C, 8'hA5, 8'hA5},
        {1'b1, C_PARK, 8'h3C, 8'h3C, 8'hA5},
        {1'b0, C_IDLE, 8'hA5, 8'h3C, 8'hA5},
        {1'b1, C_GO,   8'hA5, 8'h3C, 8'hA5},
        {1'b0, C_MOVE, 8'hA5, 8'h3C, 8'h3C},
        {1'b0, C_PARK, 8'hA5, 8'hA5, 8'h3C},
        {1'b1, C_GO,   8'h3C, 8'hA5, 8'h3C},
        {1'b1, C_MOVE, 8'h3C, 8'hA5, 8'hA5},
        {1'b0, C_PARK, 8'h3C, 8'h3C, 8'hA5},
        {1'b0, C_IDLE, 8'hA5, 8'h3C, 8'hA5}
    };

    function automatic logic [6:0] ctl_now();
        return {drv_a, drv_b, drv_t, cap_a, cap_b, cap_t, done};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        #5;
        chk("R1 ctl in reset", 32'(ctl_now()), 32'(C_IDLE));
        chk("R1 a cleared", 32'(a_val), 0);
        chk("R1 t cleared", 32'(t_val), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 idle no start", 32'(ctl_now()), 32'(C_IDLE));

        // R9: preset both registers
        @(negedge clk);
        load_a = 1'b1; a_pre = 8'h3C;
        load_b = 1'b1; b_pre = 8'hA5;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
        #1;
        chk("R9 preset a", 32'(a_val), 32'h3C);
        chk("R9 preset b", 32'(b_val), 32'hA5);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NROW; i++) begin
            if (i > 0) @(negedge clk);
            start = TBL[i][31];
            #1;
            chk($sformatf("R3 R4 R6 R8 R10 ctl row %0d", i), 32'(ctl_now()), 32'(TBL[i][30:24]));
            chk($sformatf("R5 R7 a row %0d", i), 32'(a_val), 32'(TBL[i][23:16]));
            chk($sformatf("R5 R7 b row %0d", i), 32'(b_val), 32'(TBL[i][15:8]));
            chk($sformatf("R7 t row %0d", i), 32'(t_val), 32'(TBL[i][7:0]));
        end

        // R9 collision: preset into A in the same cycle as the restore step
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        load_a = 1'b1; a_pre = 8'h77;
        #1;
        chk("R4 done at collision", 32'(done), 1);
        @(negedge clk);
        load_a = 1'b0;
        #1;
        chk("R9 preset wins a", 32'(a_val), 32'h77);
        chk("R7 b after swap", 32'(b_val), 32'hA5);
        chk("R7 t after swap", 32'(t_val), 32'h3C);
        chk("R6 done dropped", 32'(done), 0);

        // R1: asynchronous reset in first busy state
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        chk("R4 busy before reset", 32'(ctl_now()), 32'(C_MOVE));
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async ctl", 32'(ctl_now()), 32'(C_IDLE));
        chk("R1 async b", 32'(b_val), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        load_a = 1'b1; a_pre = 8'h11; load_b = 1'b1; b_pre = 8'h22;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0; start = 1'b1;
        #1;
        chk("R3 restart after reset", 32'(ctl_now()), 32'(C_GO));
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7 swap a after reset", 32'(a_val), 32'h22);
        chk("R7 swap b after reset", 32'(b_val), 32'h11);
        chk("R2 idle after swap", 32'(ctl_now()), 32'(C_IDLE));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule